// File: doc/BRIEF.md
# Inter-Processor Interrupt Hub

This block gathers up to 32 acknowledge events and turns them into one combined interrupt for the local core. Each event input is edge-detected into a sticky pending bit. A mask register selects which pending bits reach the interrupt line. The mask can be rewritten as a whole, or changed one bit at a time through a set port and a clear port. Software reads the masked status and services the set bits from the lowest upward. After handling a vector, it removes that pending bit through a write-one-to-clear register.

The same register window holds a doorbell. Bits written to it are driven toward the peer core as request lines. Each line stays high until the peer drops it through its own clear input. The register bus is a single-cycle strobe interface: writes take effect at the clock edge, and read data comes back combinationally in the same cycle as the request.

Top module: `ipc_irq_hub`

## Requirements
- R1: Pending bit k is set by a rising edge of event_i[k] and stays set until it is cleared. A clear applied while event_i[k] is still held high leaves the bit at 0, because a held level is not a new edge.
- R2: A write to offset 0x404 replaces every mask bit with the written data. Writing 0 masks every vector. Reading 0x404 returns the current mask.
- R3: A write to 0x500 sets each mask bit written as 1. A write to 0x504 clears each mask bit written as 1. In both cases, every bit written as 0 keeps its value.
- R4: A write to 0x40C clears each pending bit written as 1. Writing all ones clears every pending bit.
- R5: Reading 0x400 returns the raw pending bits, and reading 0x408 returns pending AND mask. irq_o is high exactly when that masked status is nonzero.
- R6: A write to 0x420 sets each doorbell bit written as 1 and leaves the other doorbell bits alone. bell_o holds these bits until bell_clr_i clears them. If a software set and a peer clear reach the same bit in the same cycle, the set wins. Reading 0x420 returns bell_o.
- R7: If a rising edge of an event and a clear of the same pending bit fall in the same cycle, the bit ends up set.
- R8: Reads of 0x40C, 0x500, 0x504 and of any unmapped offset return 0. Writes to 0x400 and 0x408 change no state.
- R9: Reset clears the pending, mask and doorbell registers, and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the request cycle |
| event_i | input | 32 | Acknowledge event inputs, one per vector |
| irq_o | output | 1 | Combined interrupt |
| bell_o | output | 32 | Doorbell request lines toward the peer core |
| bell_clr_i | input | 32 | Peer-side clear of the doorbell lines |

## Verification
The bench holds an event high while software clears its pending bit. A design that sets pending on the level instead of the edge would show the bit again at once. It also raises an event edge and writes a clear to the same bit in the same cycle. A design with clear-wins priority would then lose that interrupt. It presses a software doorbell write against a peer clear of the same bit, and it walks the set and clear mask ports with mixed ones and zeros. A decoder that lets the zero bits through, or treats the ports as direct writes, would corrupt unrelated mask bits. Finally, it writes ones to the read-only raw and status offsets. A design that decodes these offsets loosely would either grow pending bits there or alias them onto the mask.

// File: rtl/ipc_irq_pkg.sv
package ipc_irq_pkg;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFF_RAW   = 12'h400;
  localparam logic [ADDR_W-1:0] OFF_MASK  = 12'h404;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 12'h408;
  localparam logic [ADDR_W-1:0] OFF_CLR   = 12'h40C;
  localparam logic [ADDR_W-1:0] OFF_BELL  = 12'h420;
  localparam logic [ADDR_W-1:0] OFF_M_SET = 12'h500;
  localparam logic [ADDR_W-1:0] OFF_M_CLR = 12'h504;

  typedef enum logic [2:0] {
    RS_NONE, RS_RAW, RS_MASK, RS_STAT, RS_BELL
  } rsel_e;

  typedef struct packed {
    logic mask_wr;
    logic mask_set;
    logic mask_clr;
    logic pend_clr;
    logic bell_set;
  } wstb_t;
endpackage

// File: rtl/ipc_irq_decode.sv
module ipc_irq_decode
  import ipc_irq_pkg::*;
(
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output wstb_t             wstb_o,
  output rsel_e             rsel_o
);
  logic wr, rd;
  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  always_comb begin
    wstb_o          = '0;
    wstb_o.mask_wr  = wr && (addr_i == OFF_MASK);
    wstb_o.mask_set = wr && (addr_i == OFF_M_SET);
    wstb_o.mask_clr = wr && (addr_i == OFF_M_CLR);
    wstb_o.pend_clr = wr && (addr_i == OFF_CLR);
    wstb_o.bell_set = wr && (addr_i == OFF_BELL);
  end

  always_comb begin
    rsel_o = RS_NONE;
    if (rd) begin
      unique case (addr_i)
        OFF_RAW:  rsel_o = RS_RAW;
        OFF_MASK: rsel_o = RS_MASK;
        OFF_STAT: rsel_o = RS_STAT;
        OFF_BELL: rsel_o = RS_BELL;
        default:  rsel_o = RS_NONE;
      endcase
    end
  end
endmodule

// File: rtl/ipc_irq_pending.sv
module ipc_irq_pending #(
  parameter int NUM_VEC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_VEC-1:0] event_i,
  input  logic [NUM_VEC-1:0] clr_i,
  output logic [NUM_VEC-1:0] raw_o
);
  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    logic ev_q, bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ev_q  <= 1'b0;
        bit_q <= 1'b0;
      end else begin
        ev_q <= event_i[v];
        // new edge beats a same-cycle clear
        if (event_i[v] && !ev_q) bit_q <= 1'b1;
        else if (clr_i[v])       bit_q <= 1'b0;
      end
    end
    assign raw_o[v] = bit_q;
  end
endmodule

// File: rtl/ipc_irq_mask.sv
module ipc_irq_mask #(
  parameter int NUM_VEC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic               set_i,
  input  logic               clr_i,
  input  logic [NUM_VEC-1:0] wdata_i,
  output logic [NUM_VEC-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mask_o <= '0;
    else if (wr_i)  mask_o <= wdata_i;
    else if (set_i) mask_o <= mask_o | wdata_i;
    else if (clr_i) mask_o <= mask_o & ~wdata_i;
  end
endmodule

// File: rtl/ipc_irq_doorbell.sv
module ipc_irq_doorbell #(
  parameter int NUM_VEC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_VEC-1:0] set_i,
  input  logic [NUM_VEC-1:0] clr_i,
  output logic [NUM_VEC-1:0] bell_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bell_o <= '0;
    else         bell_o <= (bell_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/ipc_irq_hub.sv
module ipc_irq_hub
  import ipc_irq_pkg::*;
#(
  parameter int NUM_VEC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NUM_VEC-1:0] wdata_i,
  output logic [NUM_VEC-1:0] rdata_o,
  input  logic [NUM_VEC-1:0] event_i,
  output logic               irq_o,
  output logic [NUM_VEC-1:0] bell_o,
  input  logic [NUM_VEC-1:0] bell_clr_i
);
  wstb_t              wstb;
  rsel_e              rsel;
  logic [NUM_VEC-1:0] raw_q, mask_q, stat;

  ipc_irq_decode i_decode (
    .req_i  (req_i),
    .we_i   (we_i),
    .addr_i (addr_i),
    .wstb_o (wstb),
    .rsel_o (rsel)
  );

  ipc_irq_pending #(.NUM_VEC(NUM_VEC)) i_pending (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .event_i (event_i),
    .clr_i   (wdata_i & {NUM_VEC{wstb.pend_clr}}),
    .raw_o   (raw_q)
  );

  ipc_irq_mask #(.NUM_VEC(NUM_VEC)) i_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wstb.mask_wr),
    .set_i   (wstb.mask_set),
    .clr_i   (wstb.mask_clr),
    .wdata_i (wdata_i),
    .mask_o  (mask_q)
  );

  ipc_irq_doorbell #(.NUM_VEC(NUM_VEC)) i_bell (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (wdata_i & {NUM_VEC{wstb.bell_set}}),
    .clr_i  (bell_clr_i),
    .bell_o (bell_o)
  );

  assign stat  = raw_q & mask_q;
  assign irq_o = |stat;

  always_comb begin
    unique case (rsel)
      RS_RAW:  rdata_o = raw_q;
      RS_MASK: rdata_o = mask_q;
      RS_STAT: rdata_o = stat;
      RS_BELL: rdata_o = bell_o;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ipc_irq_hub_chk.sv
module ipc_irq_hub_chk
  import ipc_irq_pkg::*;
#(
  parameter int NUM_VEC = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [NUM_VEC-1:0] raw_q,
  input logic [NUM_VEC-1:0] mask_q,
  input logic               irq_o,
  input logic [NUM_VEC-1:0] bell_o,
  input logic [NUM_VEC-1:0] bell_clr_i
);
  logic wr_clr, wr_bell, wr_mask_any;
  assign wr_clr      = req_i && we_i && (addr_i == OFF_CLR);
  assign wr_bell     = req_i && we_i && (addr_i == OFF_BELL);
  assign wr_mask_any = req_i && we_i &&
                       (addr_i == OFF_MASK || addr_i == OFF_M_SET || addr_i == OFF_M_CLR);

  AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_clr |=> (($past(raw_q) & ~raw_q) == '0)); // R1

  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_mask_any |=> $stable(mask_q)); // R3

  AST_IRQ_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((raw_q & mask_q) != '0)); // R5

  AST_BELL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_bell && bell_clr_i == '0) |=> $stable(bell_o)); // R6

  AST_BELL_PEER_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_bell |=> ((bell_o & $past(bell_clr_i)) == '0)); // R6
endmodule

bind ipc_irq_hub ipc_irq_hub_chk #(.NUM_VEC(NUM_VEC)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .raw_q      (raw_q),
  .mask_q     (mask_q),
  .irq_o      (irq_o),
  .bell_o     (bell_o),
  .bell_clr_i (bell_clr_i)
);

// File: tb/test_ipc_irq_hub.sv
module test_ipc_irq_hub;
  localparam int NV = 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0, we_i = 1'b0;
  logic [11:0]   addr_i = '0;
  logic [NV-1:0] wdata_i = '0, rdata_o, event_i = '0, bell_o, bell_clr_i = '0;
  logic          irq_o;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  ipc_irq_hub #(.NUM_VEC(NV)) i_ipc_irq_hub (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .event_i(event_i), .irq_o(irq_o),
    .bell_o(bell_o), .bell_clr_i(bell_clr_i)
  );

  typedef struct packed {
    logic        we;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 17;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 12'h404, 32'h0,         32'h0,         8'd9}, // R9 mask after reset
    '{1'b1, 12'h404, 32'h0000_00F0, 32'h0,         8'd2},
    '{1'b0, 12'h404, 32'h0,         32'h0000_00F0, 8'd2}, // R2
    '{1'b1, 12'h500, 32'h0000_0101, 32'h0,         8'd3},
    '{1'b0, 12'h404, 32'h0,         32'h0000_01F1, 8'd3}, // R3 set port
    '{1'b1, 12'h504, 32'h0000_0010, 32'h0,         8'd3},
    '{1'b0, 12'h404, 32'h0,         32'h0000_01E1, 8'd3}, // R3 clear port
    '{1'b1, 12'h420, 32'h8000_0000, 32'h0,         8'd6},
    '{1'b0, 12'h420, 32'h0,         32'h8000_0000, 8'd6}, // R6
    '{1'b1, 12'h420, 32'h0000_0004, 32'h0,         8'd6},
    '{1'b0, 12'h420, 32'h0,         32'h8000_0004, 8'd6}, // R6 OR-in
    '{1'b1, 12'h400, 32'hFFFF_FFFF, 32'h0,         8'd8},
    '{1'b1, 12'h408, 32'hFFFF_FFFF, 32'h0,         8'd8},
    '{1'b0, 12'h400, 32'h0,         32'h0,         8'd8}, // R8 read-only raw
    '{1'b0, 12'h404, 32'h0,         32'h0000_01E1, 8'd8}, // R8 status write no alias
    '{1'b0, 12'h500, 32'h0,         32'h0,         8'd8}, // R8 alias reads zero
    '{1'b0, 12'h123, 32'h0,         32'h0,         8'd8}  // R8 unmapped
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #2 d = rdata_o;
    req_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    check("R9 irq_o", {31'b0, irq_o}, 32'h0);
    check("R9 bell_o", bell_o, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    bus_rd(12'h400, rd); check("R9 raw", rd, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i].we) bus_wr(VEC[i].addr, VEC[i].data);
      else begin
        bus_rd(VEC[i].addr, rd);
        check($sformatf("R%0d vec %0d", VEC[i].req, i), rd, VEC[i].exp);
      end
    end

    // R5 / R1: pending, status, irq
    bus_wr(12'h404, 32'h0000_0003);
    @(negedge clk); event_i = 32'h0000_0021;
    @(negedge clk);
    bus_rd(12'h400, rd); check("R1 raw set on edge", rd, 32'h0000_0021);
    bus_rd(12'h408, rd); check("R5 status", rd, 32'h0000_0001);
    check("R5 irq high", {31'b0, irq_o}, 32'h1);
    bus_wr(12'h404, 32'h0);
    check("R2 zero mask drops irq", {31'b0, irq_o}, 32'h0);
    bus_wr(12'h404, 32'h0000_0001);
    // R4 / R1: clear while input held high
    bus_wr(12'h40C, 32'h0000_0021);
    bus_rd(12'h400, rd); check("R1 held level no re-set", rd, 32'h0);
    check("R4 irq low after clear", {31'b0, irq_o}, 32'h0);

    // R7: edge and clear same cycle
    @(negedge clk); event_i = '0;
    @(negedge clk);
    event_i = 32'h0000_0001;
    req_i = 1'b1; we_i = 1'b1; addr_i = 12'h40C; wdata_i = 32'h0000_0001;
    @(negedge clk); req_i = 1'b0; we_i = 1'b0; wdata_i = '0;
    bus_rd(12'h400, rd); check("R7 set wins", rd, 32'h0000_0001);

    // R4: clear-all
    @(negedge clk); event_i = 32'hFFFF_FFFF; // edges on 1..31
    @(negedge clk);
    bus_rd(12'h400, rd); check("R4 all pending", rd, 32'hFFFF_FFFF);
    bus_wr(12'h40C, 32'hFFFF_FFFF);
    bus_rd(12'h400, rd); check("R4 clear all", rd, 32'h0);

    // R6: peer clear and conflict
    @(negedge clk); bell_clr_i = 32'h0000_0004;
    @(negedge clk); bell_clr_i = '0;
    check("R6 peer clear", bell_o, 32'h8000_0000);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b1; addr_i = 12'h420; wdata_i = 32'h8000_0000;
    bell_clr_i = 32'h8000_0000;
    @(negedge clk); req_i = 1'b0; we_i = 1'b0; wdata_i = '0; bell_clr_i = '0;
    check("R6 set beats peer clear", bell_o, 32'h8000_0000);
    bus_rd(12'h40C, rd); check("R8 clear reg reads zero", rd, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule